// File: doc/BRIEF.md
# Reset and Interrupt-Level Input Conditioner

This block sits between a processor's external reset and interrupt pins and the rest of its bus interface. An asynchronous, active-low reset pin is turned into an internal, clock-aligned reset. That reset asserts at once and is released only on a later rising clock edge. While the internal reset is up, the block holds every three-state enable off and every negated-level control output inactive. The memory-inhibit output and the test-port data output keep following the core.

The three active-low interrupt pins have two uses. While reset is held, their synchronized values are captured as drive-strength selects, one per output group: data bus, address/attribute, and miscellaneous control. Once reset is released, the same pins are decoded as an interrupt level equal to their bitwise inverse. The decoded level only moves after the synchronized pin value has been identical on two consecutive clocks. A nonzero level raises a pending flag. Level 7 also raises a non-maskable flag.

Top module: `rstirq_conditioner`

## Requirements
- R1: `rst_int` goes high as soon as `rst_pin_n` goes low, with no clock needed. After `rst_pin_n` returns high, `rst_int` stays high through the first rising edge and falls at the second rising edge.
- R2: From the first rising edge at which `rst_int` is high, `bus_oe` reads all zeros (three-state pins floating). Outside reset, `bus_oe` equals `core_oe` one clock later.
- R3: From the first rising edge at which `rst_int` is high, `ctl_out` reads all zeros, where 0 is the negated level. Outside reset, `ctl_out` equals `core_ctl` one clock later.
- R4: `mi_out` and `tdo_out` equal `core_mi` and `core_tdo` one clock later, whether or not reset is active.
- R5: At reset release, `drv_small` holds the pin value `irq_pin_n` that was applied for at least three clocks before `rst_pin_n` rose. Bit 2 selects the data-bus group, bit 1 the address/attribute group and bit 0 the miscellaneous control group. A 1 means small buffers and a 0 means large buffers.
- R6: Outside reset, `drv_small` never changes, whatever the interrupt pins do.
- R7: `irq_level` equals the bitwise inverse of `irq_pin_n`; for example, pins 3'b101 give level 2. A pin value held steady is reflected by the fourth rising edge after it is applied.
- R8: `irq_pend` is high exactly when `irq_level` is nonzero and `rst_int` is low. It drops as soon as `rst_int` rises, and `irq_level` reads 0 from the first edge in reset.
- R9: `irq_nmi` is high exactly when `irq_level` is 7 (pins 3'b000) and `rst_int` is low.
- R10: A pin value that is present for only one clock period, and is then replaced by the previous value, never reaches `irq_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_pin_n | input | 1 | Asynchronous reset pin, active low |
| irq_pin_n | input | 3 | Interrupt priority pins, active low, bit 2 most significant |
| core_oe | input | OE_W | Three-state enables requested by the core |
| core_ctl | input | CTL_W | Control outputs from the core, 1 = asserted |
| core_mi | input | 1 | Memory-inhibit value from the core |
| core_tdo | input | 1 | Test-port data from the core |
| rst_int | output | 1 | Internal reset, active high |
| bus_oe | output | OE_W | Gated three-state enables |
| ctl_out | output | CTL_W | Gated control outputs |
| mi_out | output | 1 | Memory-inhibit output, never gated |
| tdo_out | output | 1 | Test-port data output, never gated |
| drv_small | output | 3 | Drive-strength selects, 1 = small buffers |
| irq_level | output | 3 | Decoded interrupt level |
| irq_pend | output | 1 | Interrupt pending |
| irq_nmi | output | 1 | Level-7 non-maskable request |

## Verification
The properties take for granted that the reset pin, once low, stays low across at least one rising edge. They also take for granted that the clock keeps running during reset, so the internal reset sees a clean two-edge release. The level property assumes the pins feed only the synchronizer, so any change in `irq_level` must match the pins three edges earlier. The stimulus changes all inputs half a period away from the rising edge. It holds the reset pin low for several clocks each time. It holds each random interrupt code for at least four clocks, except for the one-period glitch cases that are deliberately shorter.

// File: rtl/rlc_pkg.sv
`timescale 1ns/1ps
package rlc_pkg;
  localparam int LVL_W = 3;
  localparam int GRP_MISC = 0;
  localparam int GRP_ADDR = 1;
  localparam int GRP_DATA = 2;

  typedef logic [LVL_W-1:0] lvl_t;

  // Active-low pin code to priority level.
  function automatic lvl_t pins_to_level(input lvl_t pins);
    return ~pins;
  endfunction

  // Group served by a given interrupt pin during reset.
  function automatic int pin_group(input int pin);
    case (pin)
      2:       return GRP_DATA;
      1:       return GRP_ADDR;
      default: return GRP_MISC;
    endcase
  endfunction
endpackage

// File: rtl/rlc_rst_sync.sv
`timescale 1ns/1ps
module rlc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_o
);
  logic [STAGES-1:0] chain;

  // Asynchronous entry, release walks through the chain.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '1;
    else         chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_o = chain[STAGES-1];
endmodule

// File: rtl/rlc_pin_sync.sv
`timescale 1ns/1ps
module rlc_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         stable
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    stg[0] <= d;
    for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    prev <= stg[STAGES-1];
  end

  assign q      = stg[STAGES-1];
  assign stable = (stg[STAGES-1] == prev);
endmodule

// File: rtl/rlc_drive_cfg.sv
`timescale 1ns/1ps
module rlc_drive_cfg import rlc_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  lvl_t pins,
  output lvl_t drv
);
  for (genvar p = 0; p < LVL_W; p++) begin : g_grp
    localparam int GRP = pin_group(p);
    // Follows the pins while reset holds, frozen afterwards.
    always_ff @(posedge clk) begin
      if (rst) drv[GRP] <= pins[p];
    end
  end
endmodule

// File: rtl/rlc_irq_decode.sv
`timescale 1ns/1ps
module rlc_irq_decode import rlc_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  lvl_t pins,
  input  logic stable,
  output lvl_t level,
  output logic pend,
  output logic nmi
);
  lvl_t nxt;
  assign nxt = pins_to_level(pins);

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      pend  <= 1'b0;
      nmi   <= 1'b0;
    end else if (stable) begin
      level <= nxt;
      pend  <= |nxt;
      nmi   <= &nxt;
    end
  end
endmodule

// File: rtl/rlc_out_gate.sv
`timescale 1ns/1ps
module rlc_out_gate #(
  parameter int         W     = 1,
  parameter bit         GATED = 1'b1,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  if (GATED) begin : g_gated
    always_ff @(posedge clk) begin
      if (rst) q <= IDLE;
      else     q <= d;
    end
  end else begin : g_free
    logic unused_rst;
    assign unused_rst = rst;
    always_ff @(posedge clk) q <= d;
  end
endmodule

// File: rtl/rstirq_conditioner.sv
`timescale 1ns/1ps
module rstirq_conditioner import rlc_pkg::*; #(
  parameter int OE_W        = 4,
  parameter int CTL_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_pin_n,
  input  logic [2:0]       irq_pin_n,
  input  logic [OE_W-1:0]  core_oe,
  input  logic [CTL_W-1:0] core_ctl,
  input  logic             core_mi,
  input  logic             core_tdo,
  output logic             rst_int,
  output logic [OE_W-1:0]  bus_oe,
  output logic [CTL_W-1:0] ctl_out,
  output logic             mi_out,
  output logic             tdo_out,
  output logic [2:0]       drv_small,
  output logic [2:0]       irq_level,
  output logic             irq_pend,
  output logic             irq_nmi
);
  localparam int FREE_W = 2;

  logic             rst_s;
  lvl_t             pin_s;
  logic             pin_stable;
  lvl_t             lvl_q;
  logic             pend_q;
  logic             nmi_q;
  logic [FREE_W-1:0] free_q;

  rlc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_pin_n), .rst_o(rst_s)
  );

  rlc_pin_sync #(.W(LVL_W), .STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .d(irq_pin_n), .q(pin_s), .stable(pin_stable)
  );

  rlc_drive_cfg u_drv (
    .clk(clk), .rst(rst_s), .pins(pin_s), .drv(drv_small)
  );

  rlc_irq_decode u_dec (
    .clk(clk), .rst(rst_s), .pins(pin_s), .stable(pin_stable),
    .level(lvl_q), .pend(pend_q), .nmi(nmi_q)
  );

  rlc_out_gate #(.W(OE_W), .GATED(1'b1), .IDLE('0)) u_oe (
    .clk(clk), .rst(rst_s), .d(core_oe), .q(bus_oe)
  );

  rlc_out_gate #(.W(CTL_W), .GATED(1'b1), .IDLE('0)) u_ctl (
    .clk(clk), .rst(rst_s), .d(core_ctl), .q(ctl_out)
  );

  rlc_out_gate #(.W(FREE_W), .GATED(1'b0), .IDLE('0)) u_free (
    .clk(clk), .rst(rst_s), .d({core_mi, core_tdo}), .q(free_q)
  );

  assign rst_int   = rst_s;
  assign mi_out    = free_q[1];
  assign tdo_out   = free_q[0];
  assign irq_level = lvl_q;
  assign irq_pend  = pend_q & ~rst_s;
  assign irq_nmi   = nmi_q & ~rst_s;
endmodule

// File: rtl/rstirq_conditioner_chk.sv
`timescale 1ns/1ps
module rstirq_conditioner_chk #(
  parameter int OE_W  = 4,
  parameter int CTL_W = 8
) (
  input logic             clk,
  input logic             rst_pin_n,
  input logic [2:0]       irq_pin_n,
  input logic             rst_int,
  input logic [OE_W-1:0]  bus_oe,
  input logic [CTL_W-1:0] ctl_out,
  input logic [2:0]       drv_small,
  input logic [2:0]       irq_level,
  input logic             irq_pend,
  input logic             irq_nmi
);
  // R1
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $fell(rst_int) |-> ($past(rst_pin_n) && $past(rst_pin_n, 2)));

  // R2
  oe_float_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $past(rst_int) |-> (bus_oe == '0));

  // R3
  ctl_negated_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $past(rst_int) |-> (ctl_out == '0));

  // R6
  drv_hold_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (!rst_int && !$past(rst_int)) |-> $stable(drv_small));

  // R7
  level_source_chk: assert property (@(posedge clk) disable iff (rst_int)
    (!$past(rst_int) && (irq_level != $past(irq_level)))
      |-> (irq_level == ~$past(irq_pin_n, 3)));

  // R8
  pend_level_chk: assert property (@(posedge clk) disable iff (rst_int)
    irq_pend |-> (irq_level != 3'd0));

  // R9
  nmi_level_chk: assert property (@(posedge clk) disable iff (rst_int)
    irq_nmi |-> (irq_level == 3'd7));
endmodule

bind rstirq_conditioner rstirq_conditioner_chk #(.OE_W(OE_W), .CTL_W(CTL_W)) u_chk (
  .clk(clk), .rst_pin_n(rst_pin_n), .irq_pin_n(irq_pin_n), .rst_int(rst_int),
  .bus_oe(bus_oe), .ctl_out(ctl_out), .drv_small(drv_small),
  .irq_level(irq_level), .irq_pend(irq_pend), .irq_nmi(irq_nmi)
);

// File: tb/rstirq_conditioner_test.sv
`timescale 1ns/1ps
module rstirq_conditioner_test;
  localparam int OE_W  = 4;
  localparam int CTL_W = 8;

  logic             clk = 1'b0;
  logic             rst_pin_n;
  logic [2:0]       irq_pin_n;
  logic [OE_W-1:0]  core_oe;
  logic [CTL_W-1:0] core_ctl;
  logic             core_mi, core_tdo;
  logic             rst_int;
  logic [OE_W-1:0]  bus_oe;
  logic [CTL_W-1:0] ctl_out;
  logic             mi_out, tdo_out;
  logic [2:0]       drv_small, irq_level;
  logic             irq_pend, irq_nmi;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  rstirq_conditioner #(.OE_W(OE_W), .CTL_W(CTL_W)) uut (
    .clk(clk), .rst_pin_n(rst_pin_n), .irq_pin_n(irq_pin_n),
    .core_oe(core_oe), .core_ctl(core_ctl), .core_mi(core_mi), .core_tdo(core_tdo),
    .rst_int(rst_int), .bus_oe(bus_oe), .ctl_out(ctl_out), .mi_out(mi_out),
    .tdo_out(tdo_out), .drv_small(drv_small), .irq_level(irq_level),
    .irq_pend(irq_pend), .irq_nmi(irq_nmi)
  );

  function automatic logic [2:0] exp_level(input logic [2:0] pins);
    return ~pins;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_core(input logic [OE_W-1:0] oe, input logic [CTL_W-1:0] ctl,
                            input logic mi, input logic tdo);
    core_oe = oe; core_ctl = ctl; core_mi = mi; core_tdo = tdo;
  endtask

  // Reset with a chosen pin code and check capture and release timing.
  task automatic reset_cycle(input logic [2:0] code);
    irq_pin_n = code;
    drive_core('1, '1, 1'b1, 1'b0);
    tick(5);
    chk(bus_oe == '0, "R2 oe in reset", bus_oe, 0);
    chk(ctl_out == '0, "R3 ctl in reset", ctl_out, 0);
    chk(mi_out == 1'b1 && tdo_out == 1'b0, "R4 free outputs in reset", {mi_out, tdo_out}, 2'b10);
    chk(irq_level == 3'd0 && !irq_pend, "R8 level cleared in reset", {irq_level, irq_pend}, 0);
    rst_pin_n = 1'b1;
    tick(1);
    chk(rst_int == 1'b1, "R1 held after first edge", rst_int, 1);
    tick(1);
    chk(rst_int == 1'b0, "R1 released at second edge", rst_int, 0);
    chk(drv_small == code, "R5 drive capture", drv_small, code);
  endtask

  initial begin
    logic [OE_W-1:0]  p_oe;
    logic [CTL_W-1:0] p_ctl;
    logic             p_mi, p_tdo;
    logic [2:0]       held;
    logic [2:0]       cap;
    void'($urandom(32'h1A2B3C4D));
    rst_pin_n = 1'b1;
    irq_pin_n = 3'b111;
    drive_core('0, '0, 1'b0, 1'b0);
    #1 rst_pin_n = 1'b0;
    #0.5;
    chk(rst_int == 1'b1, "R1 asynchronous entry", rst_int, 1);

    // Data small, address large, misc small.
    reset_cycle(3'b101);

    // Pins move after release: drive selects stay put, level 7 appears.
    irq_pin_n = 3'b000;
    tick(6);
    chk(drv_small == 3'b101, "R6 drive held", drv_small, 3'b101);
    chk(irq_level == 3'd7, "R7 level seven", irq_level, 7);
    chk(irq_nmi == 1'b1, "R9 nmi on seven", irq_nmi, 1);

    // All eight codes, checked at the fourth edge.
    for (int c = 0; c < 8; c++) begin
      irq_pin_n = c[2:0];
      tick(4);
      chk(irq_level == exp_level(c[2:0]), "R7 decode", irq_level, exp_level(c[2:0]));
      chk(irq_pend == (c != 7), "R8 pending", irq_pend, (c != 7));
      chk(irq_nmi == (c == 0), "R9 nmi", irq_nmi, (c == 0));
      chk(drv_small == 3'b101, "R6 drive held during decode", drv_small, 3'b101);
    end

    // One-period glitch must not reach the level.
    irq_pin_n = 3'b110;
    tick(5);
    irq_pin_n = 3'b011;
    tick(1);
    irq_pin_n = 3'b110;
    for (int i = 0; i < 6; i++) begin
      tick(1);
      chk(irq_level == 3'd1, "R10 glitch filtered", irq_level, 1);
    end

    // Random codes and random core outputs.
    p_oe = '0; p_ctl = '0; p_mi = 1'b0; p_tdo = 1'b0;
    drive_core(p_oe, p_ctl, p_mi, p_tdo);
    tick(1);
    for (int b = 0; b < 60; b++) begin
      held = 3'($urandom);
      irq_pin_n = held;
      for (int h = 0; h < 4 + int'($urandom % 4); h++) begin
        p_oe = OE_W'($urandom); p_ctl = CTL_W'($urandom);
        p_mi = 1'($urandom);    p_tdo = 1'($urandom);
        drive_core(p_oe, p_ctl, p_mi, p_tdo);
        tick(1);
        chk(bus_oe == p_oe, "R2 oe follows core", bus_oe, p_oe);
        chk(ctl_out == p_ctl, "R3 ctl follows core", ctl_out, p_ctl);
        chk(mi_out == p_mi && tdo_out == p_tdo, "R4 free outputs follow",
            {mi_out, tdo_out}, {p_mi, p_tdo});
      end
      chk(irq_level == exp_level(held), "R7 random decode", irq_level, exp_level(held));
      chk(irq_pend == (held != 3'b111), "R8 random pending", irq_pend, (held != 3'b111));
      chk(drv_small == 3'b101, "R6 random drive held", drv_small, 3'b101);
    end

    // Reset entry mid-run drops pending at once.
    irq_pin_n = 3'b000;
    tick(5);
    chk(irq_pend == 1'b1, "R8 pending before reset", irq_pend, 1);
    #1 rst_pin_n = 1'b0;
    #0.5;
    chk(irq_pend == 1'b0 && irq_nmi == 1'b0, "R8 pending drops on reset", {irq_pend, irq_nmi}, 0);
    chk(rst_int == 1'b1, "R1 entry mid-run", rst_int, 1);
    tick(1);

    // Opposite drive pattern, then a random one.
    reset_cycle(3'b010);
    #1 rst_pin_n = 1'b0;
    tick(1);
    cap = 3'($urandom);
    reset_cycle(cap);
    irq_pin_n = ~cap;
    tick(6);
    chk(drv_small == cap, "R6 random capture held", drv_small, cap);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule